// File: doc/BRIEF.md
# Rotate, Shift and Bit-Operation Unit

A purely combinational execution slice for an 8-bit processor. It covers the
operations that move bits around within one byte: circular rotates, rotates
through the carry flag, arithmetic and logical shifts, and the nibble exchange.
It also covers three single-bit operations that test, clear or set the bit
picked by a 3-bit index. The short accumulator rotates are included as well.
They produce the same byte as the matching long rotates but always report a
non-zero result.

The surrounding core supplies the operand and the current carry and picks the
operation. The core then takes three things back: the byte to write, a valid bit
that says whether that byte should be written at all, and the four condition
flags. The flags come with a per-flag update mask, and the core merges only the
flags whose mask bit is 1. Fetching the operand and writing back the result stay
in the core.

Top module: `rsb_unit`

## Requirements
- R1: Operation code 0 (circular rotate left) returns {operand[6:0],operand[7]}, and code 1 (circular rotate right) returns {operand[0],operand[7:1]}. In both cases the carry output is the bit that left the byte.
- R2: Operation code 2 rotates left through carry: carry_in enters bit 0 and operand[7] becomes the carry output. Code 3 rotates right through carry: carry_in enters bit 7 and operand[0] becomes the carry output.
- R3: Code 4 shifts left and fills with 0. Code 5 shifts right and keeps bit 7. Code 6 shifts right and fills with 0. In each case the carry output is the bit shifted out.
- R4: Code 7 exchanges the upper and lower nibbles and drives the carry, subtract and half-carry outputs to 0.
- R5: For codes 0 to 7, flag_z is 1 exactly when the result is zero, flag_n and flag_h are 0, result_valid is 1 and flag_upd is 4'b1111. The mask bits are ordered so that bit 3 = Z, bit 2 = N, bit 1 = H and bit 0 = C.
- R6: Codes 11, 12, 13 and 14 (accumulator forms of codes 0, 2, 1 and 3) return the same byte and carry as their long forms, with flag_z, flag_n and flag_h all 0 and flag_upd 4'b1111, even when the byte is zero.
- R7: Code 8 (bit test) drives flag_z to the inverse of operand[bit_idx], flag_n to 0 and flag_h to 1. flag_upd is 4'b1110, so carry is left alone, and result_valid is 0.
- R8: Code 9 clears operand[bit_idx] and code 10 sets it. All other bits pass through, result_valid is 1 and flag_upd is 4'b0000.
- R9: Code 15 is reserved. It gives result_valid 0 and flag_upd 4'b0000.
- R10: Flag outputs whose mask bit is 0 are driven to 0. No input other than the operation code, the index, the operand and carry_in affects the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see requirements) |
| bit_idx | input | 3 | Bit position for codes 8, 9 and 10 |
| operand | input | 8 | Byte to operate on |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Produced byte |
| result_valid | output | 1 | 1 when the core should write result back |
| flag_z | output | 1 | New zero flag |
| flag_n | output | 1 | New subtract flag |
| flag_h | output | 1 | New half-carry flag |
| flag_c | output | 1 | New carry flag |
| flag_upd | output | 4 | Per-flag update mask {Z,N,H,C} |

## Verification
The checks assume that every input is a defined 0 or 1 level. They do nothing
while the operation code still holds X, and they assume that bit_idx is always
inside the byte, which the 3-bit width enforces. The stimulus drives every input
to a known value from time zero and changes the inputs only at the falling
clock edge, so each combinational settle is observed with stable inputs. The
bench applies every code, including the reserved one. For the codes that depend
on carry_in, it drives both carry values. For the index-driven codes, it sweeps
every index.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   typedef enum logic [3:0] {
      OP_RLC  = 4'd0,
      OP_RRC  = 4'd1,
      OP_RL   = 4'd2,
      OP_RR   = 4'd3,
      OP_SLA  = 4'd4,
      OP_SRA  = 4'd5,
      OP_SRL  = 4'd6,
      OP_SWAP = 4'd7,
      OP_BIT  = 4'd8,
      OP_RES  = 4'd9,
      OP_SET  = 4'd10,
      OP_RLCA = 4'd11,
      OP_RLA  = 4'd12,
      OP_RRCA = 4'd13,
      OP_RRA  = 4'd14,
      OP_RSVD = 4'd15
   } rsb_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } rsb_flags_t;

   localparam rsb_flags_t MASK_ALL  = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
   localparam rsb_flags_t MASK_TEST = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
   localparam rsb_flags_t MASK_NONE = '0;
endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
   import rsb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  rsb_op_e             op,
   input  logic [DATA_W-1:0]   din,
   input  logic                cin,
   output logic [DATA_W-1:0]   dout,
   output logic                cout
);
   localparam int HALF_W = DATA_W / 2;

   logic msb, lsb;
   assign msb = din[DATA_W-1];
   assign lsb = din[0];

   // Normalise the short forms onto their long counterparts.
   rsb_op_e base_op;
   always_comb begin
      unique case (op)
         OP_RLCA: base_op = OP_RLC;
         OP_RLA:  base_op = OP_RL;
         OP_RRCA: base_op = OP_RRC;
         OP_RRA:  base_op = OP_RR;
         default: base_op = op;
      endcase
   end

   always_comb begin
      dout = din;
      cout = 1'b0;
      unique case (base_op)
         OP_RLC:  begin dout = {din[DATA_W-2:0], msb}; cout = msb; end
         OP_RRC:  begin dout = {lsb, din[DATA_W-1:1]}; cout = lsb; end
         OP_RL:   begin dout = {din[DATA_W-2:0], cin}; cout = msb; end
         OP_RR:   begin dout = {cin, din[DATA_W-1:1]}; cout = lsb; end
         OP_SLA:  begin dout = {din[DATA_W-2:0], 1'b0}; cout = msb; end
         OP_SRA:  begin dout = {msb, din[DATA_W-1:1]}; cout = lsb; end
         OP_SRL:  begin dout = {1'b0, din[DATA_W-1:1]}; cout = lsb; end
         OP_SWAP: begin dout = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]}; cout = 1'b0; end
         default: begin dout = din; cout = 1'b0; end
      endcase
   end
endmodule

// File: rtl/rsb_bitops.sv
module rsb_bitops
   import rsb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  rsb_op_e             op,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W-1:0]   din,
   output logic [DATA_W-1:0]   dout,
   output logic                sel_bit
);
   logic [DATA_W-1:0] onehot;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_dec
      assign onehot[gi] = (idx == IDX_W'(gi));
   end

   assign sel_bit = |(din & onehot);

   always_comb begin
      unique case (op)
         OP_RES:  dout = din & ~onehot;
         OP_SET:  dout = din | onehot;
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/rsb_flag_gen.sv
module rsb_flag_gen
   import rsb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  rsb_op_e             op,
   input  logic [DATA_W-1:0]   shift_res,
   input  logic                shift_c,
   input  logic                sel_bit,
   output rsb_flags_t          flags,
   output rsb_flags_t          upd,
   output logic                wr_en
);
   logic is_zero;
   assign is_zero = (shift_res == '0);

   always_comb begin
      flags = '0;
      upd   = MASK_NONE;
      wr_en = 1'b1;
      unique case (op)
         OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SRL, OP_SWAP: begin
            flags.z = is_zero;
            flags.c = shift_c;
            upd     = MASK_ALL;
         end
         OP_RLCA, OP_RLA, OP_RRCA, OP_RRA: begin
            flags.c = shift_c;
            upd     = MASK_ALL;
         end
         OP_BIT: begin
            flags.z = ~sel_bit;
            flags.h = 1'b1;
            upd     = MASK_TEST;
            wr_en   = 1'b0;
         end
         OP_RES, OP_SET: begin
            upd = MASK_NONE;
         end
         default: begin
            wr_en = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
   import rsb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [3:0]          op_sel,
   input  logic [IDX_W-1:0]    bit_idx,
   input  logic [DATA_W-1:0]   operand,
   input  logic                carry_in,
   output logic [DATA_W-1:0]   result,
   output logic                result_valid,
   output logic                flag_z,
   output logic                flag_n,
   output logic                flag_h,
   output logic                flag_c,
   output logic [3:0]          flag_upd
);
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("rsb_unit: DATA_W must be even and at least 2");
   end
   if ((1 << IDX_W) < DATA_W) begin : g_bad_idx
      $error("rsb_unit: IDX_W too narrow for DATA_W");
   end

   rsb_op_e           op;
   logic [DATA_W-1:0] sh_res, bo_res;
   logic              sh_c, sel_bit, wr_en;
   rsb_flags_t        flags, upd;

   assign op = rsb_op_e'(op_sel);

   rsb_shifter #(.DATA_W(DATA_W)) u_shift (
      .op(op), .din(operand), .cin(carry_in), .dout(sh_res), .cout(sh_c)
   );

   rsb_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bits (
      .op(op), .idx(bit_idx), .din(operand), .dout(bo_res), .sel_bit(sel_bit)
   );

   rsb_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .op(op), .shift_res(sh_res), .shift_c(sh_c), .sel_bit(sel_bit),
      .flags(flags), .upd(upd), .wr_en(wr_en)
   );

   assign result       = (op == OP_RES || op == OP_SET) ? bo_res : sh_res;
   assign result_valid = wr_en;
   assign flag_z       = flags.z;
   assign flag_n       = flags.n;
   assign flag_h       = flags.h;
   assign flag_c       = flags.c;
   assign flag_upd     = upd;
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input logic [3:0]          op_sel,
   input logic [IDX_W-1:0]    bit_idx,
   input logic [DATA_W-1:0]   operand,
   input logic                carry_in,
   input logic [DATA_W-1:0]   result,
   input logic                result_valid,
   input logic                flag_z,
   input logic                flag_n,
   input logic                flag_h,
   input logic                flag_c,
   input logic [3:0]          flag_upd
);
   logic [DATA_W-1:0] keep;
   assign keep = ~(DATA_W'(1) << bit_idx);

   always_comb begin
      if (!$isunknown({op_sel, bit_idx, operand, carry_in})) begin
         // R5: long rotate, shift and swap forms report zero from the byte
         if (op_sel <= 4'd7) begin
            p_zero_tracks_r5: assert (flag_z == (result == '0) && !flag_n && !flag_h)
               else $error("p_zero_tracks_r5");
         end
         // R6: short rotates never report zero
         if (op_sel >= 4'd11 && op_sel <= 4'd14) begin
            p_short_nz_r6: assert (!flag_z && flag_upd == 4'b1111)
               else $error("p_short_nz_r6");
         end
         // R7: bit test writes nothing and keeps carry
         if (op_sel == 4'd8) begin
            p_test_nowrite_r7: assert (!result_valid && flag_h && flag_upd == 4'b1110
                                       && flag_z == !operand[bit_idx])
               else $error("p_test_nowrite_r7");
         end
         // R8: clear/set touch only the indexed bit and no flag
         if (op_sel == 4'd9 || op_sel == 4'd10) begin
            p_single_bit_r8: assert (((result ^ operand) & keep) == '0 && flag_upd == 4'b0000
                                     && result[bit_idx] == (op_sel == 4'd10))
               else $error("p_single_bit_r8");
         end
         // R4: swap clears carry
         if (op_sel == 4'd7) begin
            p_swap_noc_r4: assert (!flag_c) else $error("p_swap_noc_r4");
         end
         // R9: reserved code is inert
         if (op_sel == 4'd15) begin
            p_rsvd_inert_r9: assert (!result_valid && flag_upd == 4'b0000)
               else $error("p_rsvd_inert_r9");
         end
      end
   end
endmodule

bind rsb_unit rsb_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;
   logic       clk = 1'b0;
   logic [3:0] op_sel = '0;
   logic [2:0] bit_idx = '0;
   logic [7:0] operand = '0;
   logic       carry_in = 1'b0;
   logic [7:0] result;
   logic       result_valid, flag_z, flag_n, flag_h, flag_c;
   logic [3:0] flag_upd;

   always #5 clk = ~clk;

   rsb_unit u_rsb_unit (.*);

   typedef struct {
      logic [7:0] res;
      logic       vld;
      logic [3:0] flg;   // {Z,N,H,C}
      logic [3:0] msk;
      string      req;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done  = 0;

   function automatic exp_t model(logic [3:0] op, logic [2:0] ix, logic [7:0] o,
                                  logic ci, string req);
      exp_t e;
      logic c;
      logic [7:0] r;
      e.req = req; e.vld = 1; e.msk = 4'b1111; c = 0; r = o;
      case (op)
         0, 11: begin r = {o[6:0], o[7]}; c = o[7]; end
         1, 13: begin r = {o[0], o[7:1]}; c = o[0]; end
         2, 12: begin r = {o[6:0], ci};   c = o[7]; end
         3, 14: begin r = {ci, o[7:1]};   c = o[0]; end
         4: begin r = {o[6:0], 1'b0}; c = o[7]; end
         5: begin r = {o[7], o[7:1]}; c = o[0]; end
         6: begin r = {1'b0, o[7:1]}; c = o[0]; end
         7: begin r = {o[3:0], o[7:4]}; c = 0; end
         default: ;
      endcase
      e.res = r;
      if (op <= 7)                 e.flg = {(r == 0), 1'b0, 1'b0, c};
      else if (op >= 11 && op <= 14) e.flg = {1'b0, 1'b0, 1'b0, c};
      else if (op == 8) begin
         e.flg = {~o[ix], 1'b0, 1'b1, 1'b0}; e.msk = 4'b1110; e.vld = 0;
      end else if (op == 9 || op == 10) begin
         e.res = o; e.res[ix] = (op == 10); e.flg = 0; e.msk = 0;
      end else begin
         e.flg = 0; e.msk = 0; e.vld = 0;
      end
      return e;
   endfunction

   task automatic apply(logic [3:0] op, logic [2:0] ix, logic [7:0] o, logic ci,
                        string req);
      @(negedge clk);
      op_sel = op; bit_idx = ix; operand = o; carry_in = ci;
      q.push_back(model(op, ix, o, ci, req));
   endtask

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compares settled outputs at the rising edge after each drive
   always @(posedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(result_valid == e.vld, e.req, "valid", int'(result_valid), int'(e.vld));
         if (e.vld) check(result == e.res, e.req, "result", int'(result), int'(e.res));
         check(flag_upd == e.msk, e.req, "mask", int'(flag_upd), int'(e.msk));
         // R10: unmasked flags read 0, so compare all four
         check({flag_z, flag_n, flag_h, flag_c} == e.flg, e.req, "flags",
               int'({flag_z, flag_n, flag_h, flag_c}), int'(e.flg));
      end
   end

   initial begin
      // reset state: code 0 on zero operand
      apply(4'd0, 3'd0, 8'h00, 1'b0, "R5");
      apply(4'd0, 3'd0, 8'h85, 1'b0, "R1");
      apply(4'd1, 3'd0, 8'h01, 1'b0, "R1");
      apply(4'd2, 3'd0, 8'h80, 1'b0, "R2");
      apply(4'd2, 3'd0, 8'h80, 1'b1, "R2");
      apply(4'd3, 3'd0, 8'h01, 1'b1, "R2");
      apply(4'd3, 3'd0, 8'h01, 1'b0, "R2");
      apply(4'd4, 3'd0, 8'hC3, 1'b1, "R3");
      apply(4'd5, 3'd0, 8'h81, 1'b0, "R3");
      apply(4'd6, 3'd0, 8'h81, 1'b1, "R3");
      apply(4'd6, 3'd0, 8'h01, 1'b0, "R3");
      apply(4'd7, 3'd0, 8'hA5, 1'b1, "R4");
      apply(4'd7, 3'd0, 8'h00, 1'b1, "R4");
      apply(4'd11, 3'd0, 8'h00, 1'b0, "R6");
      apply(4'd12, 3'd0, 8'h80, 1'b0, "R6");
      apply(4'd13, 3'd0, 8'h01, 1'b1, "R6");
      apply(4'd14, 3'd0, 8'h01, 1'b0, "R6");
      for (int i = 0; i < 8; i++) begin
         apply(4'd8,  3'(i), 8'h5A, 1'b1, "R7");
         apply(4'd9,  3'(i), 8'hFF, 1'b1, "R8");
         apply(4'd10, 3'(i), 8'h00, 1'b0, "R8");
      end
      apply(4'd15, 3'd2, 8'h3C, 1'b1, "R9");
      for (int op = 0; op < 16; op++)
         for (int v = 0; v < 256; v += 37)
            apply(4'(op), 3'(v), 8'(v), 1'(v), "R10");
      @(negedge clk);
      @(negedge clk);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule